// File: doc/BRIEF.md
# Vector Instruction Issue Controller

This block decides, cycle by cycle, whether the decoded vector instruction at the head of the instruction stream may start. It serves five pipelined vector units that share one register file: an adder, a multiplier, a divider, a load unit and a store unit. The register file has a single read port and a single write port. Every instruction names its target unit and an element count. A unit that is still working on earlier elements refuses new work. A shared port that would be claimed twice in the same future cycle also blocks issue. A later instruction can start while an earlier one on another unit is still streaming elements, as long as no port use overlaps.

Each unit has a countdown timer. Each port has a time-indexed slot table, in which slot k stands for the cycle k cycles from now. When an instruction starts, it claims the read slots for its operand stream and the write slots for its result stream, shifted by the unit's latency. Both tables shift down by one slot every cycle. A blocked instruction stays at the input and is retried on every cycle until it can go. At most one instruction starts per cycle, and instructions start in the order they arrive.

Top module: `vec_issue_ctrl`

## Requirements
- R1: While `rst_n` is low, no issue strobe and no stall is driven. After reset all timers and slot tables are empty, so the first valid instruction issues in the cycle it is presented.
- R2: An issue is signalled in the same cycle as the instruction, by raising exactly the strobe bit whose index equals the unit code. At most one strobe bit is high in any cycle.
- R3: `stall_o` is high exactly when `in_valid` is high and no strobe is raised. With `in_valid` low, all outputs are low.
- R4: Issuing to a unit loads its timer with element count plus unit latency. Another instruction to that unit can issue no earlier than count+latency+1 cycles after the first one.
- R5: An instruction for a reading unit (adder, multiplier, divider, store) claims the read port in the issue cycle and in the count-1 cycles after it. An instruction whose read cycles overlap an already claimed read cycle stalls.
- R6: An instruction for a writing unit (adder, multiplier, divider, load) claims the write port from latency cycles after issue, for count cycles. An instruction whose write cycles overlap an already claimed write cycle stalls.
- R7: An instruction for a free unit whose port cycles do not overlap any claimed cycle issues at once, even while earlier instructions are still streaming.
- R8: A stalled instruction is retried every cycle and issues in the first cycle in which R4 to R6 allow it. Slot tables advance by one cycle every cycle, including idle cycles.
- R9: Unit codes are 0 adder (latency 4), 1 multiplier (6), 2 divider (10), 3 load (3), 4 store (2). Codes 5 to 7 never issue and stall while valid.
- R10: An element count of 0 claims no port cycle but still keeps the unit busy for its latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Head instruction present |
| in_unit | input | 3 | Target unit code |
| in_len | input | LEN_W (6) | Element count, 0 to MAX_LEN |
| issue_o | output | 5 | One issue strobe per unit |
| stall_o | output | 1 | Head instruction held this cycle |

## Verification
Read-port claims and write-port claims can both fall on the same future cycle while two instructions stream on different units. The bench provokes this on purpose: a load runs ahead of an adder instruction that is free to read but would write into the load's result window, and a store follows a load so that it reads while the load writes. A behavioural model keeps claimed cycles as absolute cycle numbers, and its go/stall decision is compared against the strobes and the stall output on every clock. Targeted checks then compare the measured issue spacing against hand-computed values.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int UNIT_CNT = 5;
   localparam int UNIT_W   = 3;

   typedef enum logic [UNIT_W-1:0] {
      U_ADD   = 3'd0,
      U_MUL   = 3'd1,
      U_DIV   = 3'd2,
      U_LOAD  = 3'd3,
      U_STORE = 3'd4
   } unit_e;

   function automatic logic unit_reads(input logic [UNIT_W-1:0] u);
      return (u == U_ADD) || (u == U_MUL) || (u == U_DIV) || (u == U_STORE);
   endfunction

   function automatic logic unit_writes(input logic [UNIT_W-1:0] u);
      return (u == U_ADD) || (u == U_MUL) || (u == U_DIV) || (u == U_LOAD);
   endfunction
endpackage

// File: rtl/vic_unit_timer.sv
module vic_unit_timer #(
   parameter int TMR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] load_val_i,
   output logic             idle_o
);
   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load_i)       cnt <= load_val_i;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign idle_o = (cnt == '0);
endmodule

// File: rtl/vic_resv_port.sv
module vic_resv_port #(
   parameter int DEPTH = 64,
   parameter int OFS_W = 6,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_i,
   input  logic [OFS_W-1:0] ofs_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             commit_i,
   output logic             clash_o
);
   logic [DEPTH-1:0] slots;
   logic [DEPTH-1:0] want;

   always_comb begin
      for (int k = 0; k < DEPTH; k++) begin
         want[k] = use_i && (k >= int'(ofs_i)) && (k < int'(ofs_i) + int'(len_i));
      end
   end

   assign clash_o = |(slots & want);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slots <= '0;
      else        slots <= (commit_i ? (slots | want) : slots) >> 1;
   end
endmodule

// File: rtl/vec_issue_ctrl.sv
module vec_issue_ctrl
   import vic_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int MAX_LEN   = 32,
   parameter int LAT_ADD   = 4,
   parameter int LAT_MUL   = 6,
   parameter int LAT_DIV   = 10,
   parameter int LAT_LOAD  = 3,
   parameter int LAT_STORE = 2,
   localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [UNIT_W-1:0]   in_unit,
   input  logic [LEN_W-1:0]    in_len,
   output logic [UNIT_CNT-1:0] issue_o,
   output logic                stall_o
);
   localparam int LAT_TAB [UNIT_CNT] = '{LAT_ADD, LAT_MUL, LAT_DIV, LAT_LOAD, LAT_STORE};
   localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? ((LAT_DIV > LAT_ADD) ? LAT_DIV : LAT_ADD)
                                                : ((LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD);
   localparam int LAT_TOP = (LAT_MAX > LAT_LOAD) ? LAT_MAX : LAT_LOAD;
   localparam int OFS_W   = $clog2(DEPTH);
   localparam int TMR_W   = $clog2(MAX_LEN + LAT_TOP + LAT_STORE + 1);
   localparam int N_PORT  = 2;

   if (LAT_TOP + MAX_LEN > DEPTH) begin : g_bad_depth
      $error("slot table too shallow for longest write window");
   end
   if (MAX_LEN < 1 || LAT_STORE > DEPTH - 1) begin : g_bad_len
      $error("MAX_LEN must be at least 1");
   end
   if (LAT_ADD < 1 || LAT_MUL < 1 || LAT_DIV < 1 || LAT_LOAD < 1 || LAT_STORE < 1) begin : g_bad_lat
      $error("every unit latency must be at least 1");
   end

   logic [UNIT_CNT-1:0] idle;
   logic                sel_idle;
   logic [OFS_W-1:0]    sel_lat;
   logic [N_PORT-1:0]   port_use;
   logic [OFS_W-1:0]    port_ofs [N_PORT];
   logic [N_PORT-1:0]   port_clash;
   logic                go;

   always_comb begin
      sel_idle = 1'b0;
      sel_lat  = '0;
      for (int u = 0; u < UNIT_CNT; u++) begin
         if (in_unit == UNIT_W'(u)) begin
            sel_idle = idle[u];
            sel_lat  = OFS_W'(LAT_TAB[u]);
         end
      end
   end

   // port 0 = register-file read, port 1 = register-file write
   assign port_use[0] = unit_reads(in_unit);
   assign port_ofs[0] = '0;
   assign port_use[1] = unit_writes(in_unit);
   assign port_ofs[1] = sel_lat;

   assign go      = rst_n && in_valid && sel_idle && !(|port_clash);
   assign stall_o = rst_n && in_valid && !go;

   for (genvar p = 0; p < N_PORT; p++) begin : g_port
      vic_resv_port #(.DEPTH(DEPTH), .OFS_W(OFS_W), .LEN_W(LEN_W)) u_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .use_i    (port_use[p]),
         .ofs_i    (port_ofs[p]),
         .len_i    (in_len),
         .commit_i (go),
         .clash_o  (port_clash[p])
      );
   end

   for (genvar u = 0; u < UNIT_CNT; u++) begin : g_unit
      assign issue_o[u] = go && (in_unit == UNIT_W'(u));
      vic_unit_timer #(.TMR_W(TMR_W)) u_tmr (
         .clk        (clk),
         .rst_n      (rst_n),
         .load_i     (issue_o[u]),
         .load_val_i (TMR_W'(in_len) + TMR_W'(LAT_TAB[u])),
         .idle_o     (idle[u])
      );
   end
endmodule

// File: rtl/vic_issue_chk.sv
module vic_issue_chk
   import vic_pkg::*;
#(
   parameter int LEN_W = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [UNIT_W-1:0]   in_unit,
   input logic [LEN_W-1:0]    in_len,
   input logic [UNIT_CNT-1:0] issue_o,
   input logic                stall_o
);
   // R2
   onehot_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(issue_o));

   // R2
   target_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|issue_o) |-> (issue_o == (UNIT_CNT'(1) << in_unit)));

   // R3
   stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (stall_o != (|issue_o)));

   // R3
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!stall_o && issue_o == '0));

   // R9
   bad_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_unit >= UNIT_W'(UNIT_CNT)) |-> stall_o);

   // R4
   unit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|issue_o) |=> ((issue_o & $past(issue_o)) == '0));

   // R5
   rd_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|issue_o) && unit_reads(in_unit) && in_len >= LEN_W'(2))
      |=> !((|issue_o) && unit_reads(in_unit)));
endmodule

bind vec_issue_ctrl vic_issue_chk #(.LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_unit  (in_unit),
   .in_len   (in_len),
   .issue_o  (issue_o),
   .stall_o  (stall_o)
);

// File: tb/vec_issue_ctrl_bench.sv
module vec_issue_ctrl_bench;
   localparam int CLK_P = 10;
   localparam int NU    = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [2:0] in_unit;
   logic [5:0] in_len;
   logic [4:0] issue_o;
   logic       stall_o;

   vec_issue_ctrl u_vec_issue_ctrl (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
      .in_len(in_len), .issue_o(issue_o), .stall_o(stall_o)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // reference model: claimed cycles as absolute numbers
   int cyc = 0;
   int free_at [NU];
   bit rd_used [int];
   bit wr_used [int];
   int q_unit [$];
   int q_len  [$];
   int q_gap  [$];
   int icyc   [$];

   function automatic int lat_of(int u);
      case (u)
         0: return 4;  1: return 6;  2: return 10;  3: return 3;  4: return 2;
         default: return 0;
      endcase
   endfunction
   function automatic bit rd_of(int u); return (u <= 2) || (u == 4); endfunction
   function automatic bit wr_of(int u); return (u <= 3); endfunction

   function automatic bit model_go(int u, int n);
      if (u >= NU) return 0;
      if (cyc < free_at[u]) return 0;
      for (int i = 0; i < n; i++) begin
         if (rd_of(u) && rd_used.exists(cyc + i)) return 0;
         if (wr_of(u) && wr_used.exists(cyc + lat_of(u) + i)) return 0;
      end
      return 1;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // one clock: inputs set after a falling edge, compared before the rising edge
   task automatic step(string req, bit v, int u, int n, output bit went);
      bit g;
      int exp_vec;
      in_valid = v; in_unit = 3'(u); in_len = 6'(n);
      #(CLK_P/4);
      g = v && model_go(u, n);
      exp_vec = g ? (1 << u) : 0;
      check({req, " strobe"}, int'(issue_o), exp_vec);
      check({req, " stall"},  int'(stall_o), int'(v && !g));
      if (g) begin
         for (int i = 0; i < n; i++) begin
            if (rd_of(u)) rd_used[cyc + i] = 1;
            if (wr_of(u)) wr_used[cyc + lat_of(u) + i] = 1;
         end
         free_at[u] = cyc + n + lat_of(u) + 1;
      end
      went = g;
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(int k);
      bit w;
      for (int i = 0; i < k; i++) step("R3", 0, 0, 0, w);
   endtask

   task automatic push(int u, int n, int gap);
      q_unit.push_back(u); q_len.push_back(n); q_gap.push_back(gap);
   endtask

   task automatic run_queue(string req);
      bit w;
      icyc.delete();
      while (q_unit.size() > 0) begin
         for (int i = 0; i < q_gap[0]; i++) step(req, 0, 0, 0, w);
         q_gap[0] = 0;
         step(req, 1, q_unit[0], q_len[0], w);
         if (w) begin
            icyc.push_back(cyc - 1);
            void'(q_unit.pop_front()); void'(q_len.pop_front()); void'(q_gap.pop_front());
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      finish_run();
   end

   initial begin
      bit w;
      for (int u = 0; u < NU; u++) free_at[u] = 0;
      rst_n = 0; in_valid = 1; in_unit = 0; in_len = 6'd4;
      @(negedge clk);
      #1;
      // R1: held in reset, nothing driven even with a valid instruction
      check("R1 reset strobe", int'(issue_o), 0);
      check("R1 reset stall",  int'(stall_o), 0);
      in_valid = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc = 0;

      // R1 first instruction issues at once; R2 strobe matches unit
      push(1, 3, 0); run_queue("R1");
      check("R1 first issue cycle", icyc[0], 0);
      idle(60);

      // R4 same unit back to back
      push(0, 8, 0); push(0, 4, 0); run_queue("R4");
      check("R4 unit spacing", icyc[1] - icyc[0], 13);
      idle(60);

      // R5 read-port overlap
      push(1, 6, 0); push(2, 3, 0); run_queue("R5");
      check("R5 read spacing", icyc[1] - icyc[0], 6);
      idle(60);

      // R6 write-port overlap: load results vs adder results
      push(3, 8, 0); push(0, 2, 0); run_queue("R6");
      check("R6 write spacing", icyc[1] - icyc[0], 7);
      idle(60);

      // R7 overlap: store reads while load writes
      push(3, 8, 0); push(4, 8, 0); run_queue("R7");
      check("R7 overlap spacing", icyc[1] - icyc[0], 1);
      idle(60);

      // R8 table advances during idle cycles, retry until free
      push(0, 8, 0); push(1, 2, 5); run_queue("R8");
      check("R8 retry spacing", icyc[1] - icyc[0], 8);
      idle(60);

      // R10 zero-length instructions keep unit busy for latency only
      push(2, 0, 0); push(2, 1, 0); push(4, 0, 0); push(4, 0, 0); run_queue("R10");
      check("R10 div spacing",   icyc[1] - icyc[0], 11);
      check("R10 store spacing", icyc[3] - icyc[2], 3);
      idle(60);

      // R9 unknown unit codes stall while valid
      for (int i = 0; i < 4; i++) step("R9", 1, 5 + (i % 3), 2, w);
      idle(4);

      // R2 R5 R6 R7 R8 mixed stream against the model
      for (int i = 0; i < 300; i++)
         push($urandom_range(0, 4), $urandom_range(0, 32), $urandom_range(0, 2));
      run_queue("R2/R5/R6 stream");
      idle(70);

      finish_run();
   end
endmodule